// File: doc/BRIEF.md
# Redundant Checker Control Sequencer

This block is the control unit of a checker pipeline. The checker re-runs, in lock step behind a faster core, each instruction that the core has retired. The sequencer takes a new-instruction flag from the core, one correctness bit from each of the four checking stages (fetch, decode, execute, memory) and the memory stall lines. From these it decides when the checking result for the current instruction is final. When every stage agrees with the core, it emits a commit strobe. When any stage disagrees, it switches the checker's routing into execute mode, so that the checker computes the result itself. It also sends a one-cycle flush to the core, waits for that execution to finish, and then requests a reload of the core register file from the checker register file.

Completion is decided by a cycle counter. It counts a fixed number of cycles per instruction (one value for checking, a longer one for self-execution) and freezes while any memory stall line is high. A forward-progress watchdog runs from commit to commit. If it runs out while the controller is idle, the checker executes the next instruction itself and resets the core, exactly as it does after a detected mismatch.

Top module: `chk_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `commit_o`, `core_flush_o`, `rf_rollback_o` and `exec_mode_o` are all 0.
- R2: When `new_instr_i` is high in idle, checking starts at the next edge. If all four `stage_ok_i` bits are 1 after `CHK_LAT` checking cycles with no stall, `commit_o` is high for exactly one cycle, on the third cycle after the one in which the flag was seen (default `CHK_LAT`=2). The controller then returns to idle.
- R3: A cycle in which any `mem_stall_i` bit is 1 does not count towards the latency, and completion can only occur in a stall-free cycle. Each stalled cycle delays `commit_o` by one cycle.
- R4: Suppose `new_instr_i` is high in the cycle where a check completes correctly. The controller commits and starts checking the next instruction at once, so commits are spaced `CHK_LAT` cycles apart.
- R5: If any `stage_ok_i` bit is 0 when a check completes, there is no commit. Instead, `exec_mode_o` goes to 1 (1 = routing in execute mode, 0 = check or idle) and `core_flush_o` is high for exactly one cycle, in the same cycle.
- R6: In execute mode, after `EXE_LAT` stall-free cycles, `rf_rollback_o` pulses for one cycle. The controller then stays in execute mode until it samples `rollback_done_i` high. On that sample, `commit_o` pulses once, and the controller goes to checking if `new_instr_i` is high, or to idle if it is not.
- R7: If `WDOG_LIMIT` edges pass in idle and checking without a commit, the controller enters execute mode from idle and flushes the core, as in R5.
- R8: Every commit restarts the watchdog window from zero.
- R9: In idle, a new instruction takes priority over an expired watchdog, so no flush occurs.
- R10: `stage_ok_i` is ignored in every cycle except the one in which a check completes.
- R11: `rollback_done_i` has no effect in idle, in checking, or in execute mode before the rollback request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| new_instr_i | input | 1 | Core has an instruction ready to be checked |
| stage_ok_i | input | N_STAGES | Per-stage correctness: bit0 fetch, bit1 decode, bit2 execute, bit3 memory |
| mem_stall_i | input | N_STALL | Memory stall lines; any bit high freezes completion |
| rollback_done_i | input | 1 | Register-file reload has finished |
| commit_o | output | 1 | One-cycle strobe: instruction committed |
| exec_mode_o | output | 1 | Routing muxes in execute mode (1) or check mode (0) |
| core_flush_o | output | 1 | One-cycle request to flush and restart the core |
| rf_rollback_o | output | 1 | One-cycle request to reload the core register file |

## Verification
The properties assume two things about the environment. The rollback acknowledge is a level driven by the reload logic. The stall lines drop again after a bounded time, since an unbounded stall simply holds every property vacuously. The exit properties rely only on the controller sampling the acknowledge, never on when it arrives. The stimulus raises the acknowledge either after observing the rollback pulse or, on purpose, earlier in the same run to show it is ignored. It releases every stall within a few cycles and drives the correctness bits only at cycle boundaries, so they are stable across the completing cycle.

// File: rtl/chk_seq_pkg.sv
// Shared types for the checker sequencer.
// Assumes: nothing; pure type definitions.
package chk_seq_pkg;

    // Controller phase: idle, comparing core results, or self-executing.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_CHECK = 2'd1,
        SEQ_EXEC  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/chk_done_timer.sv
// Completion timer: counts stall-free cycles of the current instruction and
// flags the cycle in which the result is final.
// Assumes: active drops or done fires before the count can wrap; CHK_LAT and
// EXE_LAT are at least 1.
module chk_done_timer #(
    parameter int CHK_LAT = 2,
    parameter int EXE_LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic exec_i,
    input  logic hold_i,
    output logic done_o
);
    localparam int LAT_MAX = (CHK_LAT > EXE_LAT) ? CHK_LAT : EXE_LAT;
    localparam int CNT_W   = (LAT_MAX > 1) ? $clog2(LAT_MAX) : 1;
    localparam logic [CNT_W-1:0] CHK_END = CNT_W'(CHK_LAT - 1);
    localparam logic [CNT_W-1:0] EXE_END = CNT_W'(EXE_LAT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] end_sel;

    // Pick the terminal count for the current mode and decode completion.
    always_comb begin
        end_sel = exec_i ? EXE_END : CHK_END;
        done_o  = active_i && !hold_i && (cnt_q == end_sel);
    end

    // Count stall-free cycles; clear when idle or once complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active_i || done_o) begin
            cnt_q <= '0;
        end else if (!hold_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/chk_progress_wdog.sv
// Forward-progress watchdog: counts cycles since the last commit and reports
// expiry once WDOG_LIMIT-1 cycles have passed. Saturates while expired.
// Assumes: WDOG_LIMIT >= 2; the caller clears it on commit and while the
// checker is self-executing.
module chk_progress_wdog #(
    parameter int WDOG_LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic expired_o
);
    localparam int WD_W = (WDOG_LIMIT > 2) ? $clog2(WDOG_LIMIT) : 1;
    localparam logic [WD_W-1:0] WD_END = WD_W'(WDOG_LIMIT - 1);

    logic [WD_W-1:0] cnt_q;

    // Expiry is the saturated terminal count.
    assign expired_o = (cnt_q == WD_END);

    // Advance once per cycle until expiry; restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (!expired_o) begin
            cnt_q <= cnt_q + WD_W'(1);
        end
    end

endmodule

// File: rtl/chk_seq_fsm.sv
// Three-phase controller (idle / check / execute) with registered one-cycle
// strobes for commit, core flush and register-file rollback. Inside execute a
// flag records that the rollback was requested and the ack is awaited.
// Assumes: done_i is only meaningful while not waiting for the ack.
module chk_seq_fsm
    import chk_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       new_instr_i,
    input  logic       all_ok_i,
    input  logic       done_i,
    input  logic       wd_expired_i,
    input  logic       rb_ack_i,
    output seq_state_e state_o,
    output logic       rb_wait_o,
    output logic       commit_now_o,
    output logic       commit_o,
    output logic       flush_o,
    output logic       rollback_o
);
    seq_state_e state_q, state_d;
    logic       rb_q, rb_d;
    logic       commit_q, flush_q, rollback_q;
    logic       commit_d, flush_d, rollback_d;

    // Next phase and strobe decisions.
    always_comb begin
        state_d    = state_q;
        rb_d       = rb_q;
        commit_d   = 1'b0;
        flush_d    = 1'b0;
        rollback_d = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (new_instr_i) begin
                    state_d = SEQ_CHECK;
                end else if (wd_expired_i) begin
                    state_d = SEQ_EXEC;
                    flush_d = 1'b1;
                end
            end
            SEQ_CHECK: begin
                if (done_i) begin
                    if (all_ok_i) begin
                        commit_d = 1'b1;
                        state_d  = new_instr_i ? SEQ_CHECK : SEQ_IDLE;
                    end else begin
                        state_d = SEQ_EXEC;
                        flush_d = 1'b1;
                    end
                end
            end
            SEQ_EXEC: begin
                if (rb_q) begin
                    if (rb_ack_i) begin
                        rb_d     = 1'b0;
                        commit_d = 1'b1;
                        state_d  = new_instr_i ? SEQ_CHECK : SEQ_IDLE;
                    end
                end else if (done_i) begin
                    rb_d       = 1'b1;
                    rollback_d = 1'b1;
                end
            end
            default: begin
                state_d = SEQ_IDLE;
                rb_d    = 1'b0;
            end
        endcase
    end

    // Phase, ack-wait flag and output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_IDLE;
            rb_q       <= 1'b0;
            commit_q   <= 1'b0;
            flush_q    <= 1'b0;
            rollback_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            rb_q       <= rb_d;
            commit_q   <= commit_d;
            flush_q    <= flush_d;
            rollback_q <= rollback_d;
        end
    end

    assign state_o      = state_q;
    assign rb_wait_o    = rb_q;
    assign commit_now_o = commit_d;
    assign commit_o     = commit_q;
    assign flush_o      = flush_q;
    assign rollback_o   = rollback_q;

endmodule

// File: rtl/chk_sequencer.sv
// Top of the checker control sequencer. Combines the per-stage correctness
// bits and stall lines, runs the completion timer and progress watchdog, and
// drives the controller that commits, flushes and requests rollback.
// Assumes: inputs are synchronous to clk; stage_ok_i is stable in the
// completing cycle.
module chk_sequencer
    import chk_seq_pkg::*;
#(
    parameter int N_STAGES   = 4,
    parameter int N_STALL    = 2,
    parameter int CHK_LAT    = 2,
    parameter int EXE_LAT    = 3,
    parameter int WDOG_LIMIT = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                new_instr_i,
    input  logic [N_STAGES-1:0] stage_ok_i,
    input  logic [N_STALL-1:0]  mem_stall_i,
    input  logic                rollback_done_i,
    output logic                commit_o,
    output logic                exec_mode_o,
    output logic                core_flush_o,
    output logic                rf_rollback_o
);
    seq_state_e state;
    logic       rb_wait;
    logic       commit_now;
    logic       all_ok;
    logic       any_stall;
    logic       timer_active;
    logic       in_exec;
    logic       done;
    logic       wd_expired;
    logic       wd_clear;

    // Combine stage results and stall lines; derive timer and watchdog controls.
    always_comb begin
        all_ok       = &stage_ok_i;
        any_stall    = |mem_stall_i;
        in_exec      = (state == SEQ_EXEC);
        timer_active = (state != SEQ_IDLE) && !rb_wait;
        wd_clear     = commit_now || in_exec;
    end

    chk_done_timer #(
        .CHK_LAT (CHK_LAT),
        .EXE_LAT (EXE_LAT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (timer_active),
        .exec_i   (in_exec),
        .hold_i   (any_stall),
        .done_o   (done)
    );

    chk_progress_wdog #(
        .WDOG_LIMIT (WDOG_LIMIT)
    ) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (wd_clear),
        .expired_o (wd_expired)
    );

    chk_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .new_instr_i  (new_instr_i),
        .all_ok_i     (all_ok),
        .done_i       (done),
        .wd_expired_i (wd_expired),
        .rb_ack_i     (rollback_done_i),
        .state_o      (state),
        .rb_wait_o    (rb_wait),
        .commit_now_o (commit_now),
        .commit_o     (commit_o),
        .flush_o      (core_flush_o),
        .rollback_o   (rf_rollback_o)
    );

    assign exec_mode_o = in_exec;

endmodule

// File: rtl/chk_sequencer_sva.sv
// Property checker for chk_sequencer, attached by bind. Observes ports only,
// plus a local counter of consecutive execute-mode cycles.
// Assumes: the bound instance uses the same EXE_LAT.
module chk_sequencer_sva #(
    parameter int EXE_LAT = 3
) (
    input logic clk,
    input logic rst_n,
    input logic rollback_done_i,
    input logic commit_o,
    input logic exec_mode_o,
    input logic core_flush_o,
    input logic rf_rollback_o
);
    localparam int EW = $clog2(EXE_LAT + 2) + 1;
    localparam logic [EW-1:0] EMAX = {EW{1'b1}};

    logic [EW-1:0] exec_cycles;

    // Saturating count of consecutive cycles spent in execute mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !exec_mode_o) begin
            exec_cycles <= '0;
        end else if (exec_cycles != EMAX) begin
            exec_cycles <= exec_cycles + EW'(1);
        end
    end

    assert_flush_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        core_flush_o |=> !core_flush_o);
    assert_flush_with_exec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        core_flush_o |-> exec_mode_o);
    assert_no_commit_on_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
        core_flush_o |-> !commit_o);
    // Entry into execute, by mismatch or watchdog, always flushes the core (R7 as well).
    assert_exec_entry_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exec_mode_o) |-> core_flush_o);
    assert_rollback_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rollback_o |=> !rf_rollback_o);
    assert_rollback_after_lat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rollback_o |-> (exec_mode_o && exec_cycles >= EW'(EXE_LAT)));
    assert_exit_commits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(exec_mode_o) |-> commit_o);
    assert_exit_needs_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(exec_mode_o) |-> $past(rollback_done_i));

endmodule

bind chk_sequencer chk_sequencer_sva #(
    .EXE_LAT (EXE_LAT)
) u_sva (
    .clk             (clk),
    .rst_n           (rst_n),
    .rollback_done_i (rollback_done_i),
    .commit_o        (commit_o),
    .exec_mode_o     (exec_mode_o),
    .core_flush_o    (core_flush_o),
    .rf_rollback_o   (rf_rollback_o)
);

// File: tb/chk_sequencer_tb.sv
// Directed bench: one task per scenario. Inputs are driven and outputs sampled
// on the falling edge; n_k denotes the k-th falling edge after reset release.
module chk_sequencer_tb;
    localparam int L = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       new_instr_i = 1'b0;
    logic [3:0] stage_ok_i = 4'hF;
    logic [1:0] mem_stall_i = 2'b00;
    logic       rollback_done_i = 1'b0;
    logic       commit_o, exec_mode_o, core_flush_o, rf_rollback_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    chk_sequencer #(
        .N_STAGES (4), .N_STALL (2), .CHK_LAT (2), .EXE_LAT (3), .WDOG_LIMIT (L)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .new_instr_i (new_instr_i),
        .stage_ok_i (stage_ok_i), .mem_stall_i (mem_stall_i),
        .rollback_done_i (rollback_done_i), .commit_o (commit_o),
        .exec_mode_o (exec_mode_o), .core_flush_o (core_flush_o),
        .rf_rollback_o (rf_rollback_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_bit(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic expect_outs(input string req, input logic c, input logic m, input logic f, input logic r);
        expect_bit(req, "commit_o", commit_o, c);
        expect_bit(req, "exec_mode_o", exec_mode_o, m);
        expect_bit(req, "core_flush_o", core_flush_o, f);
        expect_bit(req, "rf_rollback_o", rf_rollback_o, r);
    endtask

    // Reset; returns at n0 with reset released. Checks R1.
    task automatic do_reset();
        rst_n = 1'b0; new_instr_i = 1'b0; stage_ok_i = 4'hF;
        mem_stall_i = 2'b00; rollback_done_i = 1'b0;
        repeat (3) tick();
        expect_outs("R1", 0, 0, 0, 0);
        rst_n = 1'b1;
        tick();
        expect_outs("R1", 0, 0, 0, 0);
        tick();
    endtask

    task automatic t_basic_R2();
        do_reset();
        new_instr_i = 1'b1; tick(); new_instr_i = 1'b0;
        expect_outs("R2", 0, 0, 0, 0);
        tick(); expect_outs("R2", 0, 0, 0, 0);
        tick(); expect_outs("R2", 1, 0, 0, 0);
        tick(); expect_outs("R2", 0, 0, 0, 0);
    endtask

    task automatic t_stall_R3();
        do_reset();
        new_instr_i = 1'b1; tick(); new_instr_i = 1'b0;
        tick(); mem_stall_i = 2'b01;
        tick(); mem_stall_i = 2'b10; expect_bit("R3", "commit_o", commit_o, 0);
        tick(); mem_stall_i = 2'b00; expect_bit("R3", "commit_o", commit_o, 0);
        tick(); expect_outs("R3", 1, 0, 0, 0);
        tick(); expect_bit("R3", "commit_o", commit_o, 0);
    endtask

    task automatic t_b2b_R4();
        do_reset();
        new_instr_i = 1'b1;
        tick(); tick(); expect_bit("R4", "commit_o", commit_o, 0);
        tick(); expect_outs("R4", 1, 0, 0, 0);
        tick(); expect_outs("R4", 0, 0, 0, 0); new_instr_i = 1'b0;
        tick(); expect_outs("R4", 1, 0, 0, 0);
        tick(); expect_outs("R4", 0, 0, 0, 0);
    endtask

    task automatic t_mismatch_R5_R6();
        do_reset();
        new_instr_i = 1'b1; tick(); new_instr_i = 1'b0; stage_ok_i = 4'b1011;
        tick();
        tick(); expect_outs("R5", 0, 1, 1, 0); stage_ok_i = 4'hF;
        tick(); expect_outs("R5", 0, 1, 0, 0);
        tick(); expect_outs("R6", 0, 1, 0, 0);
        tick(); expect_outs("R6", 0, 1, 0, 1);
        tick(); expect_outs("R6", 0, 1, 0, 0);
        tick(); expect_outs("R6", 0, 1, 0, 0);
        rollback_done_i = 1'b1; new_instr_i = 1'b1;
        tick(); expect_outs("R6", 1, 0, 0, 0);
        rollback_done_i = 1'b0; new_instr_i = 1'b0;
        tick(); expect_outs("R6", 0, 0, 0, 0);
        tick(); expect_outs("R6", 1, 0, 0, 0);
    endtask

    task automatic t_wdog_R7();
        do_reset();
        repeat (L - 3) tick();
        expect_outs("R7", 0, 0, 0, 0);
        tick(); expect_outs("R7", 0, 1, 1, 0);
        tick(); expect_outs("R7", 0, 1, 0, 0);
        tick(); tick(); expect_outs("R7", 0, 1, 0, 1);
        rollback_done_i = 1'b1;
        tick(); expect_outs("R7", 1, 0, 0, 0);
        rollback_done_i = 1'b0;
    endtask

    task automatic t_reload_R8();
        do_reset();
        repeat (L - 8) tick();
        new_instr_i = 1'b1; tick(); new_instr_i = 1'b0;
        tick(); tick(); expect_bit("R8", "commit_o", commit_o, 1);
        repeat (3) tick(); expect_bit("R8", "exec_mode_o", exec_mode_o, 0);
        repeat (L - 4) tick(); expect_bit("R8", "exec_mode_o", exec_mode_o, 0);
        tick(); expect_bit("R8", "exec_mode_o", exec_mode_o, 1);
        rollback_done_i = 1'b1; repeat (4) tick(); rollback_done_i = 1'b0; tick();
    endtask

    task automatic t_priority_R9();
        do_reset();
        repeat (L - 3) tick();
        new_instr_i = 1'b1; tick(); new_instr_i = 1'b0;
        expect_outs("R9", 0, 0, 0, 0);
        tick(); tick(); expect_outs("R9", 1, 0, 0, 0);
    endtask

    task automatic t_ok_ignored_R10();
        do_reset();
        new_instr_i = 1'b1; tick(); new_instr_i = 1'b0; stage_ok_i = 4'b0000;
        tick(); stage_ok_i = 4'hF;
        tick(); expect_outs("R10", 1, 0, 0, 0);
    endtask

    task automatic t_ack_ignored_R11();
        do_reset();
        rollback_done_i = 1'b1;
        new_instr_i = 1'b1; tick(); new_instr_i = 1'b0;
        tick(); tick(); expect_outs("R11", 1, 0, 0, 0);
        tick(); new_instr_i = 1'b1; tick(); new_instr_i = 1'b0; stage_ok_i = 4'b1110;
        tick();
        tick(); expect_outs("R11", 0, 1, 1, 0); stage_ok_i = 4'hF;
        tick(); expect_outs("R11", 0, 1, 0, 0);
        tick(); expect_outs("R11", 0, 1, 0, 0);
        tick(); expect_outs("R11", 0, 1, 0, 1);
        tick(); expect_outs("R11", 1, 0, 0, 0);
        rollback_done_i = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        t_basic_R2();
        t_stall_R3();
        t_b2b_R4();
        t_mismatch_R5_R6();
        t_wdog_R7();
        t_reload_R8();
        t_priority_R9();
        t_ok_ignored_R10();
        t_ack_ignored_R11();
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

endmodule